// File: doc/BRIEF.md
# Shared-User VBUS Power Gate

This block drives the VBUS enable of one USB port for several independent users. Each user sends single-cycle power-on and power-off request pulses. An internal use counter tracks how many users currently want power. The enable turns on only when the count leaves zero, and it turns off only when the count returns to zero. Users can therefore come and go in any order without cutting power under each other.

After reset, the first power-on request is held for a fixed start-up wait before it takes effect. This gives the port time to settle before power is first applied. The wait happens once only. Later power-on requests, including ones after the count has fallen back to zero, complete at once. A static configuration input says whether a VBUS pin exists at all. Without one, the count is still kept but the enable never rises. Two sticky flags record requests that would have wrapped the counter.

Top module: `vbus_refcount_switch`

## Requirements
- R1: A completed power-on request raises the count by one. `vbus_en` rises only on the request that takes the count from 0 to 1.
- R2: A completed power-off request lowers the count by one. `vbus_en` falls only on the request that brings the count to 0.
- R3: After reset, the first accepted power-on completes START_DELAY clock edges after the edge that samples it. Every later power-on completes on the sampling edge, until the next reset.
- R4: While the start-up wait is running, incoming on and off requests are dropped. They get no acknowledge and do not change the count.
- R5: At all times `vbus_en` equals `pin_present` AND (count nonzero). With `pin_present` low, requests still update the count.
- R6: Reset clears the count, `vbus_en`, both acknowledges and both sticky flags.
- R7: A power-off request at count 0 leaves the count at 0, is still acknowledged, and sets `udf_flag` until reset.
- R8: A power-on request at count 2^CNT_W-1 leaves the count unchanged, is still acknowledged, and sets `ovf_flag` until reset.
- R9: Each completed request produces a one-cycle pulse on its acknowledge (`on_ack` or `off_ack`). The pulse appears in the cycle after the completing edge.
- R10: When on and off requests are sampled on the same edge outside the wait, the on request is served and the off request is dropped without an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_present | input | 1 | A VBUS drive pin exists |
| on_req | input | 1 | Power-on request pulse |
| off_req | input | 1 | Power-off request pulse |
| vbus_en | output | 1 | VBUS drive enable |
| on_ack | output | 1 | Power-on completion pulse |
| off_ack | output | 1 | Power-off completion pulse |
| ovf_flag | output | 1 | Sticky: power-on at full count |
| udf_flag | output | 1 | Sticky: power-off at zero count |

## Verification
The main check sweeps every depth from 1 to 15. For each depth the bench stacks that many power-ons and then removes them, which shows that only the outermost request pair moves `vbus_en`. A run past full count and a run below zero show that the counter saturates rather than wraps. Each is confirmed by how many offs it then takes to drop power. The first power-on is checked edge by edge, with stray requests injected during the wait, and a second reset shows that the wait is re-armed. A run with the pin absent followed by enabling the pin shows that the count was kept while the output stayed low.

// File: rtl/vbus_refcount_switch.sv
module vbus_refcount_switch #(
  parameter int CNT_W       = 4,
  parameter int START_DELAY = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_present,
  input  logic on_req,
  input  logic off_req,
  output logic vbus_en,
  output logic on_ack,
  output logic off_ack,
  output logic ovf_flag,
  output logic udf_flag
);

  localparam int TMR_W = (START_DELAY > 1) ? $clog2(START_DELAY) : 1;
  localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(START_DELAY - 1);

  logic [CNT_W-1:0] cnt;
  logic [TMR_W-1:0] tmr;
  logic             armed;
  logic             waiting;

  logic cnt_full, cnt_zero;
  logic [CNT_W-1:0] cnt_up, cnt_dn;

  assign cnt_full = (cnt == {CNT_W{1'b1}});
  assign cnt_zero = (cnt == '0);
  assign cnt_up   = cnt_full ? cnt : cnt + 1'b1;
  assign cnt_dn   = cnt_zero ? cnt : cnt - 1'b1;
  assign vbus_en  = pin_present & ~cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      tmr      <= '0;
      armed    <= 1'b1;
      waiting  <= 1'b0;
      on_ack   <= 1'b0;
      off_ack  <= 1'b0;
      ovf_flag <= 1'b0;
      udf_flag <= 1'b0;
    end else begin
      on_ack  <= 1'b0;
      off_ack <= 1'b0;
      if (waiting) begin
        if (tmr == '0) begin
          waiting  <= 1'b0;
          cnt      <= cnt_up;
          ovf_flag <= ovf_flag | cnt_full;
          on_ack   <= 1'b1;
        end else begin
          tmr <= tmr - 1'b1;
        end
      end else if (on_req) begin
        armed <= 1'b0;
        if (armed && START_DELAY > 0) begin
          waiting <= 1'b1;
          tmr     <= TMR_LOAD;
        end else begin
          cnt      <= cnt_up;
          ovf_flag <= ovf_flag | cnt_full;
          on_ack   <= 1'b1;
        end
      end else if (off_req) begin
        cnt      <= cnt_dn;
        udf_flag <= udf_flag | cnt_zero;
        off_ack  <= 1'b1;
      end
    end
  end

  AST_RISE_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vbus_en) && $stable(pin_present) |-> on_ack && $past(cnt) == '0); // R1
  AST_FALL_NEEDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vbus_en) && $stable(pin_present) |-> off_ack && cnt == '0); // R2
  AST_NO_ACK_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !on_ack && !off_ack); // R4
  AST_ACK_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(on_ack && off_ack)); // R10
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    off_ack && $past(cnt) == '0 |-> cnt == '0 && udf_flag); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    on_ack && $past(cnt_full) |-> cnt_full && ovf_flag); // R8
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovf_flag) |-> ovf_flag); // R8

endmodule

// File: tb/vbus_refcount_switch_test.sv
`timescale 1ns/1ps
module vbus_refcount_switch_test;
  localparam int DLY = 6;
  localparam int MAXC = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_present = 1'b1;
  logic on_req = 1'b0;
  logic off_req = 1'b0;
  logic vbus_en, on_ack, off_ack, ovf_flag, udf_flag;

  int total = 0;
  int bad = 0;
  int exp_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  vbus_refcount_switch #(.CNT_W(4), .START_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .pin_present(pin_present),
    .on_req(on_req), .off_req(off_req), .vbus_en(vbus_en),
    .on_ack(on_ack), .off_ack(off_ack),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag));

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    exp_cnt = 0;
  endtask

  task automatic pulse(input logic on, input logic off);
    @(negedge clk);
    on_req = on;
    off_req = off;
    @(negedge clk);
    on_req = 1'b0;
    off_req = 1'b0;
  endtask

  task automatic do_on(input string tag);
    pulse(1'b1, 1'b0);
    if (exp_cnt < MAXC) exp_cnt++;
    check({tag, " on_ack"}, on_ack, 1);
    check({tag, " vbus"}, vbus_en, int'(pin_present && exp_cnt > 0));
  endtask

  task automatic do_off(input string tag);
    pulse(1'b0, 1'b1);
    if (exp_cnt > 0) exp_cnt--;
    check({tag, " off_ack"}, off_ack, 1);
    check({tag, " vbus"}, vbus_en, int'(pin_present && exp_cnt > 0));
  endtask

  task automatic first_on(input string tag);
    int acks;
    int first_seen;
    acks = 0;
    first_seen = -1;
    pulse(1'b1, 1'b0);
    for (int i = 1; i <= DLY + 2; i++) begin
      if (on_ack || off_ack) begin
        acks++;
        if (first_seen < 0) first_seen = i - 1;
      end
      if (i == 2) off_req = 1'b1;
      else if (i == 3) on_req = 1'b1;
      else begin
        off_req = 1'b0;
        on_req = 1'b0;
      end
      @(negedge clk);
    end
    exp_cnt = 1;
    check({tag, " R3 ack edge"}, first_seen, DLY);
    check({tag, " R4 single ack"}, acks, 1);
    check({tag, " R9 ack width"}, on_ack, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    check("R6 vbus", vbus_en, 0);
    check("R6 on_ack", on_ack, 0);
    check("R6 off_ack", off_ack, 0);
    check("R6 ovf", ovf_flag, 0);
    check("R6 udf", udf_flag, 0);

    first_on("first");
    check("R1 vbus after first", vbus_en, 1);
    do_off("R2 off to zero");
    do_on("R3 second on no wait");
    @(negedge clk);
    check("R9 on_ack one cycle", on_ack, 0);
    do_off("R2 back to zero");

    for (int n = 1; n <= MAXC; n++) begin
      for (int k = 0; k < n; k++) do_on("R1 sweep");
      for (int k = 0; k < n; k++) do_off("R2 sweep");
    end
    check("R8 no ovf yet", ovf_flag, 0);
    check("R7 no udf yet", udf_flag, 0);

    for (int k = 0; k < MAXC + 2; k++) do_on("R8 fill");
    check("R8 ovf sticky", ovf_flag, 1);
    for (int k = 0; k < MAXC; k++) do_off("R8 drain");
    check("R8 drained in 15", vbus_en, 0);
    check("R7 udf still clear", udf_flag, 0);

    do_off("R7 off at zero");
    check("R7 udf set", udf_flag, 1);
    do_on("R7 no wrap on");
    do_off("R7 no wrap off");
    check("R7 no wrap vbus", vbus_en, 0);

    pulse(1'b1, 1'b1);
    exp_cnt = 1;
    check("R10 on_ack", on_ack, 1);
    check("R10 off_ack", off_ack, 0);
    check("R10 vbus", vbus_en, 1);
    do_off("R10 cleanup");

    pin_present = 1'b0;
    do_reset();
    check("R6 ovf after reset", ovf_flag, 0);
    check("R6 udf after reset", udf_flag, 0);
    first_on("R3 rearm");
    check("R5 vbus no pin", vbus_en, 0);
    do_on("R5 no pin");
    do_on("R5 no pin");
    pin_present = 1'b1;
    #1;
    check("R5 count kept", vbus_en, 1);
    do_off("R5 off");
    do_off("R5 off");
    do_off("R5 last off");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule